// File: doc/BRIEF.md
# NOR Flash Program and Erase Sequencer

This block is a bus master for a parallel NOR flash. It takes one request at a time over a valid/ready handshake. A request is either a word program (target address and 16-bit data) or an erase of a sector, a block or the whole chip. The block issues the unlock and command write cycles the flash expects. It then watches the flash until the internal operation completes, and reports either success or a timeout.

Completion can be detected in three ways, chosen by a mode input that is latched with the request:
- comparing DQ6 across two back-to-back reads (toggle bit);
- matching DQ7 against the true value of the written data (data polling);
- waiting for the ready/busy pin to return high.

Each bus strobe lasts a parameterised number of clocks. Each operation class has its own timeout limit, because a chip erase runs several times longer than a sector erase, and an erase runs thousands of times longer than a program.

Top module: `nor_prog_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle, and a request is taken on a clock where `req_valid` and `req_ready` are both high. While an operation runs, `req_valid` has no effect: no extra bus writes are issued and the running operation is not altered.
- R2: A program (`req_op`=0) issues four writes, as (address, data): (555h, 00AAh), (2AAh, 0055h), (555h, 00A0h), then (target, data).
- R3: A sector erase (`req_op`=1) issues six writes: (555h, 00AAh), (2AAh, 0055h), (555h, 0080h), (555h, 00AAh), (2AAh, 0055h), then (target, 0050h).
- R4: A block erase (`req_op`=2) issues the same first five writes as R3 and ends with (target, 0030h). A chip erase (`req_op`=3) issues the same first five writes and ends with (555h, 0010h).
- R5: In every bus cycle, `flash_ce_n` and the active strobe (`flash_we_n` for a write, `flash_oe_n` for a read) are low for exactly STROBE consecutive clocks. During a write, the address and the driven data stay stable with `flash_dq_oe` high. The two strobes are never low together, and `flash_ce_n` is high for at least one clock between cycles.
- R6: With `poll_mode`=0 (toggle), the sequencer reads the target address repeatedly. It completes when two consecutive reads return the same DQ6.
- R7: With `poll_mode`=1 (data polling), the sequencer reads the target address. It completes when DQ7 equals bit 7 of the programmed data for a program, or equals 1 for any erase.
- R8: With `poll_mode`=2 or 3 (ready/busy), the sequencer issues no reads. It completes when the synchronised `flash_rdy` is high, once at least RDY_BLANK clocks of the wait phase have passed.
- R9: On completion, `op_done` is high for exactly one clock and `req_ready` is high on the next clock.
- R10: If completion is not seen within the limit for the operation class, `op_err` is high for one clock, `op_done` stays low, and the sequencer returns to idle. The limit is PROG_TMO for a program, ERASE_TMO for a sector or block erase, and CHIP_TMO for a chip erase, counted in clocks from the end of the last command write.
- R11: During and after reset, `flash_ce_n`, `flash_we_n` and `flash_oe_n` are high, `flash_dq_oe`, `op_done` and `op_err` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Target word address (program, sector, block; poll address for all) |
| req_data | input | 16 | Program data |
| poll_mode | input | 2 | 0 toggle bit, 1 data polling, 2/3 ready/busy pin |
| flash_addr | output | AW | Flash address bus |
| flash_dq_out | output | 16 | Data driven to the flash |
| flash_dq_oe | output | 1 | Drive enable for `flash_dq_out` |
| flash_dq_in | input | 16 | Data read from the flash |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_rdy | input | 1 | Ready/busy pin, high when ready (asynchronous) |
| op_done | output | 1 | One-clock completion pulse |
| op_err | output | 1 | One-clock timeout pulse |

## Verification
The bench sweeps every operation against every completion mode, using a flash model that stays busy for a set number of clocks and then settles.

The corner cases are these:
- Two reads taken during the busy phase always differ in DQ6, so a toggle check that compared one read with itself would finish early.
- The DQ7 reference must be 1 for erases but the data bit for programs, so both values of data bit 7 are exercised.
- The ready pin is still high right after the last write, so a sequencer without blanking would report done at once.
- A timeout is forced for each limit class, so a design that used one limit for all would report the error at the wrong time.
- A request is held valid during a running operation, which exposes a design that accepts it.

// File: rtl/nor_seq_pkg.sv
// Shared encodings for the NOR flash program/erase sequencer.
// Assumes: operation and poll-mode codes match the top-level port encoding.
package nor_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_SECT  = 2'd1,
        OP_BLK   = 2'd2,
        OP_CHIP  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PM_TOGGLE = 2'd0,
        PM_DATA   = 2'd1,
        PM_RDY    = 2'd2,
        PM_RDY_B  = 2'd3
    } pmode_e;

    typedef enum logic [1:0] {
        B_IDLE  = 2'd0,
        B_PULSE = 2'd1,
        B_GAP   = 2'd2
    } bus_st_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_CMD  = 3'd1,
        S_POLL = 3'd2,
        S_OK   = 3'd3,
        S_ERR  = 3'd4
    } seq_st_e;

    localparam logic [7:0] UNLOCK_1 = 8'hAA;
    localparam logic [7:0] UNLOCK_2 = 8'h55;
    localparam logic [7:0] CMD_PROG = 8'hA0;
    localparam logic [7:0] CMD_ERS  = 8'h80;
    localparam logic [7:0] CMD_SECT = 8'h50;
    localparam logic [7:0] CMD_BLK  = 8'h30;
    localparam logic [7:0] CMD_CHIP = 8'h10;

endpackage

// File: rtl/nor_cmd_table.sv
// Command-cycle table: maps (operation, step index) to the address/data of
// one bus write and flags the final write of the sequence.
// Assumes: AW >= 11 so the unlock addresses fit; purely combinational.
module nor_cmd_table
    import nor_seq_pkg::*;
#(
    parameter int AW = 21
) (
    input  op_e           op,
    input  logic [2:0]    step,
    input  logic [AW-1:0] tgt_addr,
    input  logic [15:0]   tgt_data,
    output logic [AW-1:0] wr_addr,
    output logic [15:0]   wr_data,
    output logic          wr_last
);

    localparam logic [AW-1:0] ADDR_A = AW'(12'h555);
    localparam logic [AW-1:0] ADDR_B = AW'(12'h2AA);

    // Select address, data and last flag for the current step.
    always_comb begin
        wr_addr = ADDR_A;
        wr_data = {8'h00, UNLOCK_1};
        wr_last = 1'b0;
        case (step)
            3'd0: begin
                wr_addr = ADDR_A;
                wr_data = {8'h00, UNLOCK_1};
            end
            3'd1: begin
                wr_addr = ADDR_B;
                wr_data = {8'h00, UNLOCK_2};
            end
            3'd2: begin
                wr_addr = ADDR_A;
                wr_data = {8'h00, (op == OP_PROG) ? CMD_PROG : CMD_ERS};
            end
            3'd3: begin
                if (op == OP_PROG) begin
                    wr_addr = tgt_addr;
                    wr_data = tgt_data;
                    wr_last = 1'b1;
                end else begin
                    wr_addr = ADDR_A;
                    wr_data = {8'h00, UNLOCK_1};
                end
            end
            3'd4: begin
                wr_addr = ADDR_B;
                wr_data = {8'h00, UNLOCK_2};
            end
            default: begin
                wr_last = 1'b1;
                case (op)
                    OP_SECT: begin
                        wr_addr = tgt_addr;
                        wr_data = {8'h00, CMD_SECT};
                    end
                    OP_BLK: begin
                        wr_addr = tgt_addr;
                        wr_data = {8'h00, CMD_BLK};
                    end
                    default: begin
                        wr_addr = ADDR_A;
                        wr_data = {8'h00, CMD_CHIP};
                    end
                endcase
            end
        endcase
    end

endmodule

// File: rtl/nor_bus_cycle.sv
// Single flash bus cycle engine: on go, runs one write or read with the
// strobe low for STROBE clocks, followed by one recovery clock with all
// strobes high. For reads, the two status bits are captured in the final
// strobe clock.
// Assumes: go is only raised while idle is high; STROBE >= 1.
module nor_bus_cycle
    import nor_seq_pkg::*;
#(
    parameter int AW     = 21,
    parameter int STROBE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          go_write,
    input  logic [AW-1:0] go_addr,
    input  logic [15:0]   go_data,
    output logic          idle,
    output logic          fin,
    output logic [1:0]    stat,
    output logic [AW-1:0] bus_addr,
    output logic [15:0]   bus_dq,
    output logic          bus_dq_oe,
    input  logic [1:0]    stat_in,
    output logic          ce_n,
    output logic          we_n,
    output logic          oe_n
);

    localparam int CW = (STROBE > 1) ? $clog2(STROBE) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(STROBE - 1);

    bus_st_e        st_q;
    logic [CW-1:0]  cnt_q;
    logic           wr_q;

    // Cycle state, strobe counter, latched address/data and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= B_IDLE;
            cnt_q    <= '0;
            wr_q     <= 1'b0;
            bus_addr <= '0;
            bus_dq   <= '0;
            stat     <= '0;
        end else begin
            case (st_q)
                B_IDLE: begin
                    if (go) begin
                        st_q     <= B_PULSE;
                        cnt_q    <= CNT_TOP;
                        wr_q     <= go_write;
                        bus_addr <= go_addr;
                        bus_dq   <= go_data;
                    end
                end
                B_PULSE: begin
                    if (cnt_q == '0) begin
                        st_q <= B_GAP;
                        if (!wr_q) stat <= stat_in;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: st_q <= B_IDLE;
            endcase
        end
    end

    // Pin and handshake decode from the registered state.
    always_comb begin
        idle      = (st_q == B_IDLE);
        fin       = (st_q == B_GAP);
        ce_n      = !(st_q == B_PULSE);
        we_n      = !(st_q == B_PULSE && wr_q);
        oe_n      = !(st_q == B_PULSE && !wr_q);
        bus_dq_oe = (st_q != B_IDLE) && wr_q;
    end

    // R5: a new cycle is only requested while the engine is free.
    p_go_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (st_q == B_IDLE));

    // R5: the recovery clock always follows a strobe and ends it.
    p_gap_after_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == B_GAP) |=> ce_n);

endmodule

// File: rtl/nor_tmo_timer.sv
// Wait-phase timer: counts clocks while run is high, saturates at limit and
// flags expiry. clr restarts it. The elapsed count is exported for the
// ready-pin blanking window.
// Assumes: limit is held stable during a run.
module nor_tmo_timer #(
    parameter int TW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic [TW-1:0] elapsed,
    output logic          expired
);

    // Saturating count and sticky expiry flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            elapsed <= '0;
            expired <= 1'b0;
        end else if (run && (elapsed < limit)) begin
            elapsed <= elapsed + 1'b1;
            expired <= ((elapsed + 1'b1) >= limit);
        end
    end

    // R10: once expired, the count no longer moves.
    p_tmo_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clr) |=> (elapsed == $past(elapsed)));

endmodule

// File: rtl/nor_prog_seq.sv
// NOR flash program/erase sequencer (top).
// Takes one request over valid/ready, issues the command writes from
// nor_cmd_table through nor_bus_cycle, then detects completion by toggle
// bit, data polling or the ready pin. A per-class timeout is kept by
// nor_tmo_timer. Reports op_done or op_err for one clock.
// Assumes: flash_rdy is asynchronous (two-flop synchroniser inside);
// CHIP_TMO is the largest timeout and RDY_BLANK does not exceed any limit.
module nor_prog_seq
    import nor_seq_pkg::*;
#(
    parameter int AW        = 21,
    parameter int STROBE    = 4,
    parameter int PROG_TMO  = 2000,
    parameter int ERASE_TMO = 4_000_000,
    parameter int CHIP_TMO  = 8_000_000,
    parameter int RDY_BLANK = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_data,
    input  logic [1:0]    poll_mode,
    output logic [AW-1:0] flash_addr,
    output logic [15:0]   flash_dq_out,
    output logic          flash_dq_oe,
    input  logic [15:0]   flash_dq_in,
    output logic          flash_ce_n,
    output logic          flash_we_n,
    output logic          flash_oe_n,
    input  logic          flash_rdy,
    output logic          op_done,
    output logic          op_err
);

    localparam int MAX_A = (PROG_TMO > ERASE_TMO) ? PROG_TMO : ERASE_TMO;
    localparam int MAX_T = (MAX_A > CHIP_TMO) ? MAX_A : CHIP_TMO;
    localparam int TW    = $clog2(MAX_T + 1);

    seq_st_e        st_q;
    op_e            op_q;
    pmode_e         mode_q;
    logic [AW-1:0]  addr_q;
    logic [15:0]    data_q;
    logic [2:0]     step_q;
    logic           prev6_q;
    logic           have_prev_q;
    logic           rdy_s1_q, rdy_s2_q;

    logic [AW-1:0]  cw_addr;
    logic [15:0]    cw_data;
    logic           cw_last;

    logic           bus_go, bus_idle, bus_fin;
    logic [1:0]     bus_stat;

    logic [TW-1:0]  tmo_limit, tmo_elapsed;
    logic           tmo_exp;

    logic           rd_mode, exp7, poll_hit;

    logic           unused_dq;
    assign unused_dq = ^{flash_dq_in[15:8], flash_dq_in[5:0]};

    nor_cmd_table #(.AW(AW)) u_cmd (
        .op       (op_q),
        .step     (step_q),
        .tgt_addr (addr_q),
        .tgt_data (data_q),
        .wr_addr  (cw_addr),
        .wr_data  (cw_data),
        .wr_last  (cw_last)
    );

    nor_bus_cycle #(.AW(AW), .STROBE(STROBE)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (bus_go),
        .go_write  (st_q == S_CMD),
        .go_addr   ((st_q == S_CMD) ? cw_addr : addr_q),
        .go_data   (cw_data),
        .idle      (bus_idle),
        .fin       (bus_fin),
        .stat      (bus_stat),
        .bus_addr  (flash_addr),
        .bus_dq    (flash_dq_out),
        .bus_dq_oe (flash_dq_oe),
        .stat_in   (flash_dq_in[7:6]),
        .ce_n      (flash_ce_n),
        .we_n      (flash_we_n),
        .oe_n      (flash_oe_n)
    );

    nor_tmo_timer #(.TW(TW)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (st_q != S_POLL),
        .run     (st_q == S_POLL),
        .limit   (tmo_limit),
        .elapsed (tmo_elapsed),
        .expired (tmo_exp)
    );

    // Timeout limit chosen by operation class.
    always_comb begin
        case (op_q)
            OP_PROG: tmo_limit = TW'(PROG_TMO);
            OP_CHIP: tmo_limit = TW'(CHIP_TMO);
            default: tmo_limit = TW'(ERASE_TMO);
        endcase
    end

    // Poll decode: read-based mode, DQ7 reference and per-read hit test.
    always_comb begin
        rd_mode  = (mode_q == PM_TOGGLE) || (mode_q == PM_DATA);
        exp7     = (op_q == OP_PROG) ? data_q[7] : 1'b1;
        poll_hit = (mode_q == PM_TOGGLE) ? (have_prev_q && (bus_stat[0] == prev6_q))
                                         : (bus_stat[1] == exp7);
        bus_go   = bus_idle && ((st_q == S_CMD) ||
                                (st_q == S_POLL && rd_mode && !tmo_exp));
    end

    // Two-flop synchroniser for the asynchronous ready pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_s1_q <= 1'b0;
            rdy_s2_q <= 1'b0;
        end else begin
            rdy_s1_q <= flash_rdy;
            rdy_s2_q <= rdy_s1_q;
        end
    end

    // Sequencer state machine: accept, command writes, poll, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= S_IDLE;
            op_q        <= OP_PROG;
            mode_q      <= PM_TOGGLE;
            addr_q      <= '0;
            data_q      <= '0;
            step_q      <= '0;
            prev6_q     <= 1'b0;
            have_prev_q <= 1'b0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (req_valid) begin
                        st_q   <= S_CMD;
                        op_q   <= op_e'(req_op);
                        mode_q <= pmode_e'(poll_mode);
                        addr_q <= req_addr;
                        data_q <= req_data;
                        step_q <= '0;
                    end
                end
                S_CMD: begin
                    if (bus_fin) begin
                        if (cw_last) begin
                            st_q        <= S_POLL;
                            have_prev_q <= 1'b0;
                        end else begin
                            step_q <= step_q + 1'b1;
                        end
                    end
                end
                S_POLL: begin
                    if (rd_mode) begin
                        if (bus_fin) begin
                            prev6_q     <= bus_stat[0];
                            have_prev_q <= 1'b1;
                            if (poll_hit) st_q <= S_OK;
                        end else if (tmo_exp && bus_idle) begin
                            st_q <= S_ERR;
                        end
                    end else begin
                        if (rdy_s2_q && (tmo_elapsed >= TW'(RDY_BLANK))) st_q <= S_OK;
                        else if (tmo_exp) st_q <= S_ERR;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // Handshake and report outputs.
    always_comb begin
        req_ready = (st_q == S_IDLE);
        op_done   = (st_q == S_OK);
        op_err    = (st_q == S_ERR);
    end

    // R1: idle means the bus is quiet and nothing is being reported.
    p_ready_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (flash_ce_n && !op_done && !op_err));

    // R5: address held stable across a strobe.
    p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_ce_n && $past(!flash_ce_n)) |-> $stable(flash_addr));

    // R5: write data held stable across the write strobe.
    p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_we_n && $past(!flash_we_n)) |-> ($stable(flash_dq_out) && flash_dq_oe));

    // R5: write and read strobes never overlap.
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_we_n && !flash_oe_n));

    // R8: ready-pin mode never reads the flash.
    p_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_POLL && !rd_mode) |-> flash_oe_n);

    // R9: done is a single-clock pulse followed by idle.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> (!op_done && req_ready));

    // R10: error is a single-clock pulse followed by idle, never with done.
    p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |=> (!op_err && !op_done && req_ready));

endmodule

// File: tb/nor_prog_seq_tb_top.sv
// Self-checking bench: a behavioural flash model stays busy for a set number
// of clocks after the final command write. All operations are swept against
// all poll modes, and then timeouts and held requests are exercised.
module nor_prog_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW        = 21;
    localparam int STROBE    = 3;
    localparam int PROG_TMO  = 60;
    localparam int ERASE_TMO = 90;
    localparam int CHIP_TMO  = 130;
    localparam int RDY_BLANK = 4;
    localparam int FOREVER   = 32'h7fff_ffff;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_data = '0;
    logic [1:0]    poll_mode = '0;
    logic [AW-1:0] flash_addr;
    logic [15:0]   flash_dq_out;
    logic          flash_dq_oe;
    logic [15:0]   flash_dq_in;
    logic          flash_ce_n, flash_we_n, flash_oe_n;
    logic          flash_rdy;
    logic          op_done, op_err;

    int checks = 0;
    int failures = 0;

    // flash model state
    int            cyc = 0;
    int            n_exp = 4;
    int            busy_len = 20;
    logic          m_exp7 = 1'b0;
    logic [AW-1:0] m_tgt = '0;
    logic          busy = 1'b0;
    int            busy_left = 0;
    int            busy_t0 = 0;
    logic          tog = 1'b0;
    int            wcnt = 0, rcnt = 0, rd_bad = 0, len_bad = 0;
    int            wlen = 0, rlen = 0;
    logic          prev_we = 1'b1, prev_oe = 1'b1;
    logic [AW-1:0] w_addr [0:15];
    logic [15:0]   w_data [0:15];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign flash_dq_in = {8'h00, (busy ? ~m_exp7 : m_exp7), tog, 6'h00};
    assign flash_rdy   = !busy;

    nor_prog_seq #(
        .AW(AW), .STROBE(STROBE), .PROG_TMO(PROG_TMO), .ERASE_TMO(ERASE_TMO),
        .CHIP_TMO(CHIP_TMO), .RDY_BLANK(RDY_BLANK)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .poll_mode(poll_mode), .flash_addr(flash_addr), .flash_dq_out(flash_dq_out),
        .flash_dq_oe(flash_dq_oe), .flash_dq_in(flash_dq_in), .flash_ce_n(flash_ce_n),
        .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n), .flash_rdy(flash_rdy),
        .op_done(op_done), .op_err(op_err)
    );

    // Flash model: records writes, measures strobes, runs the busy phase.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (prev_we && !flash_we_n) begin
            if (wcnt < 16) begin
                w_addr[wcnt] = flash_addr;
                w_data[wcnt] = flash_dq_out;
            end
            wcnt = wcnt + 1;
            wlen = 1;
        end else if (!flash_we_n) begin
            wlen = wlen + 1;
        end
        if (!prev_we && flash_we_n) begin
            if (wlen != STROBE) len_bad = len_bad + 1;
            if (wcnt == n_exp) begin
                busy = 1'b1;
                busy_left = busy_len;
                busy_t0 = cyc;
            end
        end else if (busy) begin
            if (busy_left <= 1) busy = 1'b0;
            else busy_left = busy_left - 1;
        end
        if (prev_oe && !flash_oe_n) begin
            rcnt = rcnt + 1;
            rlen = 1;
            if (flash_addr != m_tgt) rd_bad = rd_bad + 1;
            if (busy) tog = ~tog;
        end else if (!flash_oe_n) begin
            rlen = rlen + 1;
        end
        if (!prev_oe && flash_oe_n && rlen != STROBE) len_bad = len_bad + 1;
        prev_we = flash_we_n;
        prev_oe = flash_oe_n;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        failures = failures + 1;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected command write i for an operation (R2/R3/R4).
    task automatic exp_write(input int op, input int i, input logic [AW-1:0] a,
                             input logic [15:0] d, output logic [AW-1:0] ea,
                             output logic [15:0] ed);
        logic [7:0] cmd3;
        case (i)
            0, 3: begin ea = AW'('h555); ed = 16'h00AA; end
            1, 4: begin ea = AW'('h2AA); ed = 16'h0055; end
            2:    begin ea = AW'('h555); ed = (op == 0) ? 16'h00A0 : 16'h0080; end
            default: begin ea = AW'('h555); ed = 16'h0000; end
        endcase
        if (op == 0 && i == 3) begin ea = a; ed = d; end
        if (i == 5) begin
            cmd3 = (op == 1) ? 8'h50 : (op == 2) ? 8'h30 : 8'h10;
            ea = (op == 3) ? AW'('h555) : a;
            ed = {8'h00, cmd3};
        end
    endtask

    // Run one operation end to end and check it.
    task automatic run_op(input int op, input int mode, input logic [AW-1:0] a,
                          input logic [15:0] d, input int blen, input bit want_err,
                          input bit hold_valid);
        int lim, waited, t_end;
        bit got_done, got_err, busy_at_done;
        logic [AW-1:0] ea;
        logic [15:0] ed;
        n_exp = (op == 0) ? 4 : 6;
        busy_len = blen;
        m_exp7 = (op == 0) ? d[7] : 1'b1;
        m_tgt = a;
        busy = 1'b0; tog = 1'b0;
        wcnt = 0; rcnt = 0; rd_bad = 0; len_bad = 0;
        lim = (op == 0) ? PROG_TMO : (op == 3) ? CHIP_TMO : ERASE_TMO;
        chk(req_ready == 1'b1, "R1 ready before request", req_ready, 1);
        req_op = op[1:0]; req_addr = a; req_data = d; poll_mode = mode[1:0];
        req_valid = 1'b1;
        step();
        if (hold_valid) begin
            req_op = 2'd3; req_data = ~d; req_addr = ~a;
        end else begin
            req_valid = 1'b0;
        end
        chk(req_ready == 1'b0, "R1 ready low while busy", req_ready, 0);
        got_done = 0; got_err = 0; busy_at_done = 0; waited = 0; t_end = 0;
        while (!got_done && !got_err && waited < 3000) begin
            step();
            waited = waited + 1;
            if (hold_valid && waited == 20)
                chk(req_ready == 1'b0, "R1 held request not taken", req_ready, 0);
            if (op_done) begin got_done = 1; busy_at_done = busy; t_end = cyc; end
            if (op_err)  begin got_err = 1; t_end = cyc; end
        end
        req_valid = 1'b0;
        if (want_err) begin
            chk(got_err && !got_done, "R10 timeout reported", got_err, 1);
            chk((t_end - busy_t0) >= lim && (t_end - busy_t0) <= lim + STROBE + 6,
                "R10 timeout window", t_end - busy_t0, lim);
        end else begin
            chk(got_done && !got_err, "R9 completion reported", got_done, 1);
            chk(!busy_at_done, "R6 R7 R8 no early completion", busy_at_done, 0);
        end
        step();
        chk(req_ready && !op_done && !op_err, "R9 back to idle after report", req_ready, 1);
        chk(wcnt == n_exp, "R1 R2 R3 R4 write count", wcnt, n_exp);
        for (int i = 0; i < n_exp && i < wcnt; i++) begin
            exp_write(op, i, a, d, ea, ed);
            chk(w_addr[i] == ea, (op == 0) ? "R2 write addr" : (op == 1) ? "R3 write addr" : "R4 write addr",
                w_addr[i], ea);
            chk(w_data[i] == ed, (op == 0) ? "R2 write data" : (op == 1) ? "R3 write data" : "R4 write data",
                w_data[i], ed);
        end
        chk(len_bad == 0, "R5 strobe width", len_bad, 0);
        if (mode >= 2) begin
            chk(rcnt == 0, "R8 no reads in ready mode", rcnt, 0);
        end else begin
            chk(rcnt >= 2 && rd_bad == 0, (mode == 0) ? "R6 reads at target" : "R7 reads at target",
                rd_bad, 0);
        end
        step();
    endtask

    initial begin
        repeat (3) step();
        chk(flash_ce_n && flash_we_n && flash_oe_n, "R11 strobes idle in reset",
            {flash_ce_n, flash_we_n, flash_oe_n}, 3'b111);
        chk(!flash_dq_oe && !op_done && !op_err, "R11 outputs low in reset",
            {flash_dq_oe, op_done, op_err}, 0);
        rst_n = 1'b1;
        step();
        chk(req_ready && flash_ce_n, "R11 ready after reset", req_ready, 1);

        // Sweep: every operation against every poll mode.
        for (int op = 0; op < 4; op++) begin
            for (int m = 0; m < 3; m++) begin
                run_op(op, m, AW'(21'h0F_1000 + op * 21'h8000 + m * 21'h10),
                       (m == 2) ? 16'hC3A5 : 16'h5A3C, 20, 1'b0, 1'b0);
            end
        end
        // R7: program data with bit 7 set under data polling.
        run_op(0, 1, AW'(21'h00_0123), 16'h00A5, 25, 1'b0, 1'b0);
        // R8: code 3 also selects the ready pin.
        run_op(2, 3, AW'(21'h10_8000), 16'h0000, 15, 1'b0, 1'b0);
        // R10: each limit class times out with a never-ready flash.
        run_op(0, 2, AW'(21'h00_0400), 16'h1111, FOREVER, 1'b1, 1'b0);
        run_op(1, 0, AW'(21'h01_0800), 16'h0000, FOREVER, 1'b1, 1'b0);
        run_op(3, 1, AW'(21'h00_0000), 16'h0000, FOREVER, 1'b1, 1'b0);
        // R1: request held valid through a running operation.
        run_op(0, 0, AW'(21'h02_0002), 16'h7E81, 30, 1'b0, 1'b1);
        repeat (5) step();
        chk(wcnt == 4 && req_ready, "R1 no extra writes after held request", wcnt, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule